// File: doc/BRIEF.md
# SPI Register Access Slave with Burst Transfers

This block lets an external SPI host reach a 64-entry, byte-wide register space inside the chip. Each selection of the slave begins with one command byte. Its top bit picks the direction, the next bit picks whether the address steps forward after every data byte, and the six low bits hold the starting address. Any number of data bytes may follow. The transfer ends only when the host releases the active-low select.

The block oversamples the host's SPI pins through short synchronisers clocked by the register-bus clock. On the chip side it drives a single-cycle write strobe or read strobe with a shared address. A read strobe returns its data on the next cycle, the same way a block RAM does. When the address is held fixed, every byte of a burst hits the same location. This is how FIFO-style register files are pushed or drained in a single burst.

A registered output-enable marks the read data phases. It lets the serial output share one bidirectional wire with the serial input in 3-wire systems.

Top module: `spireg_top`

## Requirements
- R1: Command bit 7 set makes the transaction a write, which issues one `reg_wr` strobe per data byte. Command bit 7 clear makes it a read, which issues `reg_rd` strobes. The two strobes are never high in the same cycle.
- R2: With command bit 6 set, the address used for each data byte is one greater than the one used for the byte before it. With command bit 6 clear, the address stays constant.
- R3: Command bits 5..0 give the first address. Every byte is 8 bits, sent MSB first and sampled on the rising edge of `sck`.
- R4: A burst may hold any number of data bytes and ends only when `ss_n` goes high. No strobe occurs while the slave is deselected, and every new selection begins again with a command byte.
- R5: In a fixed-address burst every byte accesses the same location. Bytes pushed to a FIFO register therefore come back in the same order from a fixed-address read burst.
- R6: Read data goes out on `miso` MSB first and changes after falling edges of `sck`. The first bit of each data byte is valid before that byte's first rising edge. The host keeps `sck` low whenever `ss_n` falls.
- R7: `sdo_oe` is high only during the data phase of a selected read. It is low during the command byte, throughout writes, and while deselected.
- R8: When the address increments past 0x3F it wraps to 0x00.
- R9: A read issues one single-cycle `reg_rd` at the end of the command byte and one at the end of each data byte, so N data bytes produce N+1 strobes. `reg_rdata` is taken one cycle after each strobe.
- R10: After reset, `reg_wr`, `reg_rd`, `miso` and `sdo_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock, also used to oversample the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| ss_n | input | 1 | Active-low slave select from the host |
| sck | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | High while `miso` should drive a shared data wire |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_addr | output | 6 | Register address for the current strobe |
| reg_wdata | output | 8 | Write data qualified by `reg_wr` |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
Some properties are checked by assertions on every cycle:
- the two strobes are exclusive;
- no strobe appears while deselected;
- read strobes are never issued back to back;
- the output enable never overlaps a write;
- `sck` is low at each select edge.

Other behaviour can only be shown by the bench's scenarios, which model a register array plus one FIFO location and compare against values computed from the address:
- command decoding at every address;
- incrementing and wrapping bursts;
- fixed-address FIFO streaming;
- MSB-first read timing;
- the exact number of read strobes per burst.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int BYTE_W     = 8;
  localparam int REG_ADDR_W = 6;

  typedef struct packed {
    logic                  dir_wr;
    logic                  step;
    logic [REG_ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)      chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= din;
      else          chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spireg_frame.sv
module spireg_frame
  import spireg_pkg::*;
#(
  parameter int AW = REG_ADDR_W,
  parameter int DW = BYTE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ss_s,
  input  logic                   sck_s,
  input  logic                   mosi_s,
  output logic                   reg_wr,
  output logic                   reg_rd,
  output logic [AW-1:0]          reg_addr,
  output logic [DW-1:0]          reg_wdata,
  output logic [$clog2(DW)-1:0]  bit_cnt,
  output logic                   rd_phase,
  output logic                   sck_fall
);
  localparam int BW = $clog2(DW);

  logic          sck_q;
  logic [DW-1:0] rx_sh;
  logic          in_cmd, is_wr, step_q;
  logic [AW-1:0] addr_q;

  wire           active    = ~ss_s;
  wire           sck_rise  = sck_s & ~sck_q;
  wire [DW-1:0]  byte_in   = {rx_sh[DW-2:0], mosi_s};
  cmd_t          cmd;
  assign cmd      = cmd_t'(byte_in);
  assign sck_fall = ~sck_s & sck_q;
  assign rd_phase = active & ~in_cmd & ~is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q     <= 1'b0;
      rx_sh     <= '0;
      bit_cnt   <= '0;
      in_cmd    <= 1'b1;
      is_wr     <= 1'b0;
      step_q    <= 1'b0;
      addr_q    <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      sck_q  <= sck_s;
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
        in_cmd  <= 1'b1;
        is_wr   <= 1'b0;
      end else if (sck_rise) begin
        rx_sh   <= byte_in;
        bit_cnt <= bit_cnt + BW'(1);
        if (bit_cnt == BW'(DW-1)) begin
          if (in_cmd) begin
            in_cmd <= 1'b0;
            is_wr  <= cmd.dir_wr;
            step_q <= cmd.step;
            if (cmd.dir_wr) begin
              addr_q <= cmd.addr;
            end else begin
              reg_rd   <= 1'b1;
              reg_addr <= cmd.addr;
              addr_q   <= cmd.addr + AW'(cmd.step);
            end
          end else if (is_wr) begin
            reg_wr    <= 1'b1;
            reg_addr  <= addr_q;
            reg_wdata <= byte_in;
            addr_q    <= addr_q + AW'(step_q);
          end else begin
            reg_rd   <= 1'b1;
            reg_addr <= addr_q;
            addr_q   <= addr_q + AW'(step_q);
          end
        end
      end
    end
  end

  p_one_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_wr, reg_rd}));

  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (ss_s && $past(ss_s)) |-> (!reg_wr && !reg_rd));

  p_rd_spaced_r9: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);
endmodule

// File: rtl/spireg_txshift.sv
module spireg_txshift #(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_stb,
  input  logic [DW-1:0]         rdata,
  input  logic                  sck_fall,
  input  logic [$clog2(DW)-1:0] bit_cnt,
  input  logic                  rd_phase,
  output logic                  miso,
  output logic                  oe
);
  logic [DW-1:0] tx_sh;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      rd_q  <= 1'b0;
      oe    <= 1'b0;
    end else begin
      rd_q <= rd_stb;
      oe   <= rd_phase;
      if (rd_q)
        tx_sh <= rdata;
      else if (sck_fall && rd_phase && bit_cnt != '0)
        tx_sh <= {tx_sh[DW-2:0], 1'b0};
    end
  end

  assign miso = tx_sh[DW-1];
endmodule

// File: rtl/spireg_top.sv
module spireg_top
  import spireg_pkg::*;
#(
  parameter int AW          = REG_ADDR_W,
  parameter int DW          = BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ss_n,
  input  logic          sck,
  input  logic          mosi,
  output logic          miso,
  output logic          sdo_oe,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);
  localparam int BW = $clog2(DW);

  logic [2:0]    pins_s;
  logic [BW-1:0] bit_cnt;
  logic          rd_phase, sck_fall;
  logic          ss_q;

  spireg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .din({ss_n, sck, mosi}), .dout(pins_s)
  );

  spireg_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk(clk), .rst(rst), .ss_s(pins_s[2]), .sck_s(pins_s[1]), .mosi_s(pins_s[0]),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .bit_cnt(bit_cnt), .rd_phase(rd_phase), .sck_fall(sck_fall)
  );

  spireg_txshift #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .rd_stb(reg_rd), .rdata(reg_rdata), .sck_fall(sck_fall),
    .bit_cnt(bit_cnt), .rd_phase(rd_phase), .miso(miso), .oe(sdo_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) ss_q <= 1'b1;
    else     ss_q <= pins_s[2];
  end

  p_no_oe_on_write_r7: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> !sdo_oe);

  p_sck_low_at_select_r6: assert property (@(posedge clk) disable iff (rst)
    (ss_q && !pins_s[2]) |-> !pins_s[1]);
endmodule

// File: tb/tb_spireg_top.sv
module tb_spireg_top;
  localparam int HALF = 10;
  localparam logic [5:0] FIFO_A = 6'h30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ss_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, sdo_oe, reg_wr, reg_rd;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  always #2.5 clk = ~clk;

  spireg_top dut (
    .clk(clk), .rst(rst), .ss_n(ss_n), .sck(sck), .mosi(mosi), .miso(miso),
    .sdo_oe(sdo_oe), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  logic [7:0] mem [64];
  logic [7:0] fifo [16];
  logic [3:0] wp = '0, rp = '0;
  int rd_cnt = 0, wr_cnt = 0, oe_cnt = 0;

  always @(posedge clk) begin
    if (reg_wr) begin
      wr_cnt <= wr_cnt + 1;
      if (reg_addr == FIFO_A) begin fifo[wp] <= reg_wdata; wp <= wp + 4'd1; end
      else mem[reg_addr] <= reg_wdata;
    end
    if (reg_rd) begin
      rd_cnt <= rd_cnt + 1;
      if (reg_addr == FIFO_A) begin reg_rdata <= fifo[rp]; rp <= rp + 4'd1; end
      else reg_rdata <= mem[reg_addr];
    end
    if (sdo_oe) oe_cnt <= oe_cnt + 1;
  end

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input int n);
    logic [7:0] dummy;
    ss_n = 1'b0;
    repeat (HALF) @(negedge clk);
    xbyte(cmd, dummy);
    for (int k = 0; k < n; k++) xbyte(wbuf[k], rbuf[k]);
    repeat (HALF) @(negedge clk);
    ss_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int r0, w0, o0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 reg_wr", reg_wr, 0);
    chk("R10 reg_rd", reg_rd, 0);
    chk("R10 miso", miso, 0);
    chk("R10 sdo_oe", sdo_oe, 0);

    // R1 R3: single write then single read at every plain address
    for (int a = 0; a < 64; a++) begin
      if (a == FIFO_A) continue;
      wbuf[0] = pat(a);
      xfer(8'h80 | 8'(a), 1);
    end
    for (int a = 0; a < 64; a++) begin
      if (a == FIFO_A) continue;
      xfer(8'(a), 1);
      chk("R1 R3 single read", rbuf[0], pat(a));
    end

    // R2 R8 R7: incrementing write from 0x3C wraps to 0x03
    for (int k = 0; k < 8; k++) wbuf[k] = 8'hA0 + 8'(k);
    w0 = wr_cnt; o0 = oe_cnt;
    xfer(8'hC0 | 8'h3C, 8);
    chk("R1 write strobes", wr_cnt - w0, 8);
    chk("R7 oe during write", oe_cnt - o0, 0);
    for (int k = 0; k < 8; k++) wbuf[k] = 8'h00;
    r0 = rd_cnt; o0 = oe_cnt;
    xfer(8'h40 | 8'h3C, 8);
    for (int k = 0; k < 8; k++) chk("R2 R8 inc read", rbuf[k], 8'hA0 + k);
    chk("R9 read strobes", rd_cnt - r0, 9);
    chk("R7 oe during read", (oe_cnt - o0) > 0, 1);
    chk("R7 oe after deselect", sdo_oe, 0);
    xfer(8'h04, 1);
    chk("R8 beyond wrap untouched", rbuf[0], pat(4));

    // R2 fixed read repeats one address
    xfer(8'h3D, 3);
    for (int k = 0; k < 3; k++) chk("R2 fixed read", rbuf[k], 8'hA1);

    // R5 fixed write keeps address; neighbour untouched
    for (int k = 0; k < 4; k++) wbuf[k] = 8'h50 + 8'(k);
    xfer(8'h80 | 8'h10, 4);
    xfer(8'h10, 1);
    chk("R5 fixed write last", rbuf[0], 8'h53);
    xfer(8'h11, 1);
    chk("R5 neighbour", rbuf[0], pat(17));

    // R5 R4 FIFO stream: push 6, pop 5 in order
    for (int k = 0; k < 6; k++) wbuf[k] = 8'h11 * 8'(k + 1);
    xfer(8'h80 | 8'(FIFO_A), 6);
    r0 = rd_cnt;
    xfer(8'(FIFO_A), 5);
    for (int k = 0; k < 5; k++) chk("R5 R6 fifo order", rbuf[k], 8'h11 * (k + 1));
    chk("R9 fifo strobes", rd_cnt - r0, 6);
    chk("R4 idle strobes", reg_rd | reg_wr, 0);

    // R6 MSB-first with distinct bit patterns
    wbuf[0] = 8'h81; xfer(8'h80 | 8'h20, 1);
    wbuf[0] = 8'h7E; xfer(8'h80 | 8'h21, 1);
    xfer(8'h60, 2);
    chk("R6 msb pattern 0", rbuf[0], 8'h81);
    chk("R6 msb pattern 1", rbuf[1], 8'h7E);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule